// File: doc/BRIEF.md
# Conversion Start and Interrupt Routing Controller

This block decides when the analog-to-digital converter is told to start a conversion. Software picks one of three start sources through a 2-bit field of an 8-bit control register. The sources are a software start strobe, a rising edge seen on an asynchronous external trigger pin, and the on-chip pacer tick. A flop clocked by the trigger pin itself catches pulses much shorter than a clock period. It holds them as a sticky status flag until software writes to the status address with any data.

The same control register gates DMA requests and interrupts. End-of-conversion and DMA terminal-count events set a pending interrupt while interrupts are enabled. The 3-bit level code routes that pending interrupt onto one of the bus request lines 2 to 7. Lines 0 and 1 are never driven, and a code of 0 or 1 drives nothing. A status write also clears the pending interrupt.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After reset, the control read-back is 0x00, and conv_start, trig_flag, dma_req and all irq_lines are 0.
- R2: A ctrl_wr strobe stores ctrl_wdata. Read-back returns it from the next cycle, with bit 3 always reading 0. Field positions: bit 7 interrupt enable, bits 6..4 level code, bit 2 DMA enable, bits 1..0 start source.
- R3: With start source 00 or 01, conv_start pulses for one cycle in the cycle after sw_start is sampled. Pacer ticks and external edges start nothing.
- R4: With start source 10, a rising edge on ext_trig starts one conversion. conv_start rises after the third clock edge following the pulse. sw_start and pacer ticks are ignored.
- R5: With start source 11, each pacer_tick gives one conv_start pulse in the next cycle. sw_start is ignored.
- R6: A trigger pulse shorter than a clock period sets trig_flag after the second clock edge that follows it. The flag stays set, in any start mode, until a status write.
- R7: A stat_clr strobe clears trig_flag from the next cycle. Trigger pulses arriving while the flag is set start no further conversion; after the clear, a new pulse is accepted again.
- R8: With interrupts enabled, an eoc_evt or dma_tc pulse sets a pending interrupt. That interrupt shows as irq_lines bit N, where N is the level code, from the next cycle on.
- R9: Level codes 0 and 1 drive no irq_lines bit, and irq_lines bits 1..0 are never 1.
- R10: stat_clr clears the pending interrupt. An event sampled in the same cycle as the clear leaves it pending.
- R11: dma_req equals dma_rdy while the DMA enable bit is 1, and is 0 otherwise.
- R12: With interrupt enable 0, events are not recorded. Setting the enable afterwards raises no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read-back |
| stat_clr | input | 1 | Status address write strobe (data ignored) |
| trig_flag | output | 1 | Sticky caught-trigger status flag |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| sw_start | input | 1 | Software conversion start strobe |
| pacer_tick | input | 1 | One-cycle pacer output pulse |
| conv_start | output | 1 | One-cycle conversion start pulse |
| eoc_evt | input | 1 | End-of-conversion event pulse |
| dma_tc | input | 1 | DMA terminal-count event pulse |
| dma_rdy | input | 1 | Converter has data for a DMA transfer |
| dma_req | output | 1 | Gated DMA request |
| irq_lines | output | 8 | Bus interrupt request lines, one-hot |

## Verification
The hardest situation to reach is a second external pulse that arrives while the first is still latched. It must leave the flag and the start output untouched, and the next pulse after a status write must be accepted again. The stimulus fires a sub-cycle pulse midway between clock edges in external mode. It fires a second pulse a few cycles later, clears with a status write, waits out the clear window and fires a third pulse. A behavioural model follows catcher, synchroniser and pending state on every clock. The bench also counts start pulses per phase.

// File: rtl/acq_trig_pkg.sv
// Shared types for the conversion start and interrupt routing controller.
// Assumes an 8-bit control word whose field positions are decoded by software.
package acq_trig_pkg;
    localparam int CTRL_W = 8;
    localparam int LVL_W  = 3;

    typedef enum logic [1:0] {
        SRC_SOFT_A = 2'b00,
        SRC_SOFT_B = 2'b01,
        SRC_EXT    = 2'b10,
        SRC_PACE   = 2'b11
    } start_src_e;

    typedef struct packed {
        logic             irq_en;
        logic [LVL_W-1:0] irq_lvl;
        logic             unused;
        logic             dma_en;
        start_src_e       src;
    } ctrl_word_t;
endpackage

// File: rtl/trig_catch.sv
// Catches an asynchronous trigger pulse in a flop clocked by the pin itself,
// brings the caught state into the clock domain through SYNC_STAGES flops,
// and flags its rising edge. Assumes clr is a one-cycle synchronous strobe;
// the catcher is held clear for the cycle after clr.
module trig_catch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic flag,
    output logic rise
);
    logic                   clr_q;
    logic                   caught;
    logic                   catch_rst_n;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Registers the clear so the async catcher reset is glitch free.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= clr;
    end

    assign catch_rst_n = rst_n & ~clr_q;

    // Pulse catcher: any rising pin edge sets it until cleared.
    always_ff @(posedge pin or negedge catch_rst_n) begin
        if (!catch_rst_n) caught <= 1'b0;
        else              caught <= 1'b1;
    end

    // Synchroniser chain, one flop per stage.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sync_q[g] <= 1'b0;
            else if (clr) sync_q[g] <= 1'b0;
            else if (g == 0) sync_q[g] <= caught;
            else          sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
        end
    end

    // Holds the previous synchronised value for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   last_q <= 1'b0;
        else if (clr) last_q <= 1'b0;
        else          last_q <= sync_q[SYNC_STAGES-1];
    end

    assign flag = sync_q[SYNC_STAGES-1];
    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/start_select.sv
// Chooses the conversion start source and issues a registered one-cycle
// start pulse. Assumes all event inputs are synchronous single-cycle pulses.
module start_select
    import acq_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  start_src_e src,
    input  logic       sw_start,
    input  logic       ext_rise,
    input  logic       pacer_tick,
    output logic       conv_start
);
    logic start_d;

    // Picks the event that counts as a start in the current mode.
    always_comb begin
        unique case (src)
            SRC_EXT:  start_d = ext_rise;
            SRC_PACE: start_d = pacer_tick;
            default:  start_d = sw_start;
        endcase
    end

    // Registers the start pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) conv_start <= 1'b0;
        else        conv_start <= start_d;
    end
endmodule

// File: rtl/irq_route.sv
// Holds a pending interrupt set by conversion or terminal-count events and
// drives it onto the request line chosen by the level code. Lines below
// FIRST_LINE are never driven. Assumes events and clr are one-cycle pulses.
module irq_route #(
    parameter int LVL_BITS   = 3,
    parameter int FIRST_LINE = 2,
    localparam int N_LINES   = 1 << LVL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_en,
    input  logic [LVL_BITS-1:0] lvl,
    input  logic                eoc_evt,
    input  logic                dma_tc,
    input  logic                clr,
    output logic [N_LINES-1:0]  lines
);
    logic pend_q;

    // Pending flag: new events win over a simultaneous clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~clr) | (irq_en & (eoc_evt | dma_tc));
    end

    // Per-line decode; forbidden low lines are tied off.
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        if (i < FIRST_LINE) begin : g_off
            assign lines[i] = 1'b0;
        end else begin : g_on
            assign lines[i] = pend_q & irq_en & (lvl == LVL_BITS'(i));
        end
    end
endmodule

// File: rtl/acq_trig_ctrl.sv
// Top of the conversion start and interrupt routing controller: holds the
// control word, gates DMA requests and ties catcher, start select and
// interrupt routing together. Assumes ctrl_wr and stat_clr are one-cycle
// strobes from an external bus decoder.
module acq_trig_ctrl
    import acq_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FIRST_LINE  = 2,
    localparam int N_LINES    = 1 << LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              stat_clr,
    output logic              trig_flag,
    input  logic              ext_trig,
    input  logic              sw_start,
    input  logic              pacer_tick,
    output logic              conv_start,
    input  logic              eoc_evt,
    input  logic              dma_tc,
    input  logic              dma_rdy,
    output logic              dma_req,
    output logic [N_LINES-1:0] irq_lines
);
    ctrl_word_t ctrl_q;
    ctrl_word_t ctrl_in;
    logic       ext_rise;

    assign ctrl_in = ctrl_word_t'(ctrl_wdata);

    // Control word register; the unused bit is never stored.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q        <= ctrl_in;
            ctrl_q.unused <= 1'b0;
        end
    end

    assign ctrl_rdata = ctrl_q;
    assign dma_req    = ctrl_q.dma_en & dma_rdy;

    trig_catch #(.SYNC_STAGES(SYNC_STAGES)) u_catch (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_trig),
        .clr   (stat_clr),
        .flag  (trig_flag),
        .rise  (ext_rise)
    );

    start_select u_start (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (ctrl_q.src),
        .sw_start   (sw_start),
        .ext_rise   (ext_rise),
        .pacer_tick (pacer_tick),
        .conv_start (conv_start)
    );

    irq_route #(.LVL_BITS(LVL_W), .FIRST_LINE(FIRST_LINE)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_en  (ctrl_q.irq_en),
        .lvl     (ctrl_q.irq_lvl),
        .eoc_evt (eoc_evt),
        .dma_tc  (dma_tc),
        .clr     (stat_clr),
        .lines   (irq_lines)
    );
endmodule

// File: rtl/acq_trig_ctrl_chk.sv
// Property checker for acq_trig_ctrl, attached by bind.
module acq_trig_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_wr,
    input logic [7:0] ctrl_wdata,
    input logic [7:0] ctrl_rdata,
    input logic       stat_clr,
    input logic       trig_flag,
    input logic       ext_trig,
    input logic       sw_start,
    input logic       pacer_tick,
    input logic       conv_start,
    input logic       eoc_evt,
    input logic       dma_tc,
    input logic       dma_rdy,
    input logic       dma_req,
    input logic [7:0] irq_lines
);
    // R2
    always @(posedge clk) begin
        if (rst_n) rsvd_zero_chk: assert (ctrl_rdata[3] == 1'b0);
    end

    // R3
    soft_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && $past(ctrl_rdata[1] == 1'b0)) |-> $past(sw_start));

    // R5
    pace_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && $past(ctrl_rdata[1:0] == 2'b11)) |-> $past(pacer_tick));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_flag && !stat_clr) |=> trig_flag);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> !trig_flag);

    // R8
    line_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lines));

    // R9
    low_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lines[1:0] == 2'b00);

    // R12
    line_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines != 8'h00) |-> ctrl_rdata[7]);

    // R11
    dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[2] |-> !dma_req);
endmodule

bind acq_trig_ctrl acq_trig_ctrl_chk u_chk (.*);

// File: tb/sim_acq_trig_ctrl.sv
module sim_acq_trig_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] ctrl_rdata;
    logic       stat_clr = 1'b0;
    logic       trig_flag;
    logic       ext_trig = 1'b0;
    logic       sw_start = 1'b0;
    logic       pacer_tick = 1'b0;
    logic       conv_start;
    logic       eoc_evt = 1'b0;
    logic       dma_tc = 1'b0;
    logic       dma_rdy = 1'b0;
    logic       dma_req;
    logic [7:0] irq_lines;

    int checks = 0;
    int errors = 0;
    int conv_cnt = 0;
    bit done = 1'b0;
    string phase = "R1";

    // reference model state
    logic [7:0] m_ctrl;
    logic m_catch, m_s1, m_s2, m_s3, m_conv, m_irq;

    always #4 clk = ~clk;

    acq_trig_ctrl u0 (.*);

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // model: pin catcher
    always @(posedge ext_trig) m_catch = 1'b1;

    // model: one clock step
    always @(posedge clk) begin
        logic n_conv, n_irq;
        if (!rst_n) begin
            m_ctrl = 8'h00; m_catch = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0;
            m_s3 = 1'b0; m_conv = 1'b0; m_irq = 1'b0;
        end else begin
            case (m_ctrl[1:0])
                2'b10:   n_conv = m_s2 & ~m_s3;
                2'b11:   n_conv = pacer_tick;
                default: n_conv = sw_start;
            endcase
            n_irq = (m_irq & ~stat_clr) | (m_ctrl[7] & (eoc_evt | dma_tc));
            if (stat_clr) begin
                m_s1 = 1'b0; m_s2 = 1'b0; m_s3 = 1'b0; m_catch = 1'b0;
            end else begin
                m_s3 = m_s2; m_s2 = m_s1; m_s1 = m_catch;
            end
            m_conv = n_conv;
            m_irq  = n_irq;
            if (ctrl_wr) m_ctrl = ctrl_wdata & 8'hF7;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int lvl;
            int exp_lines;
            lvl = int'(m_ctrl[6:4]);
            exp_lines = (m_ctrl[7] && m_irq && lvl >= 2) ? (1 << lvl) : 0;
            cmp(phase, "conv_start", int'(conv_start), int'(m_conv));
            cmp(phase, "trig_flag", int'(trig_flag), int'(m_s2));
            cmp(phase, "irq_lines", int'(irq_lines), exp_lines);
            cmp(phase, "dma_req", int'(dma_req), int'(m_ctrl[2] & dma_rdy));
            cmp(phase, "ctrl_rdata", int'(ctrl_rdata), int'(m_ctrl));
            if (conv_start) conv_cnt++;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk); #1 ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); #1 ctrl_wr = 1'b0;
    endtask

    task automatic strobe(input int which);
        @(negedge clk); #1;
        case (which)
            0: sw_start = 1'b1;
            1: pacer_tick = 1'b1;
            2: eoc_evt = 1'b1;
            3: dma_tc = 1'b1;
            default: stat_clr = 1'b1;
        endcase
        @(negedge clk); #1;
        sw_start = 1'b0; pacer_tick = 1'b0; eoc_evt = 1'b0; dma_tc = 1'b0; stat_clr = 1'b0;
    endtask

    task automatic ext_pulse();
        @(negedge clk); #2 ext_trig = 1'b1; #1 ext_trig = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        cmp("R1", "ctrl_rdata", int'(ctrl_rdata), 0);
        cmp("R1", "outputs", int'({conv_start, trig_flag, dma_req}), 0);
        cmp("R1", "irq_lines", int'(irq_lines), 0);
        #1 rst_n = 1'b1;
        idle(2);

        // R2: read-back with unused bit masked
        phase = "R2";
        write_ctrl(8'h0F);
        cmp("R2", "ctrl_rdata", int'(ctrl_rdata), 8'h07);
        write_ctrl(8'h00);

        // R3: software mode
        phase = "R3";
        conv_cnt = 0;
        strobe(0); strobe(1); ext_pulse(); idle(5);
        cmp("R3", "start count", conv_cnt, 1);
        strobe(4); idle(3);

        // R4 / R7: external edge mode
        phase = "R4";
        write_ctrl(8'h02);
        conv_cnt = 0;
        strobe(0); strobe(1);
        ext_pulse(); idle(5);
        cmp("R4", "start count", conv_cnt, 1);
        phase = "R6";
        cmp("R6", "trig_flag held", int'(trig_flag), 1);
        phase = "R7";
        ext_pulse(); idle(5);
        cmp("R7", "start count while latched", conv_cnt, 1);
        strobe(4);
        cmp("R7", "trig_flag after clear", int'(trig_flag), 0);
        idle(2);
        ext_pulse(); idle(5);
        cmp("R7", "start count after clear", conv_cnt, 2);
        strobe(4); idle(2);

        // R5: pacer mode
        phase = "R5";
        write_ctrl(8'h03);
        conv_cnt = 0;
        strobe(1); strobe(0); strobe(1); strobe(1); idle(3);
        cmp("R5", "start count", conv_cnt, 3);

        // R8: interrupt routing
        phase = "R8";
        write_ctrl(8'hD0);
        strobe(2);
        cmp("R8", "irq_lines level 5", int'(irq_lines), 8'h20);
        strobe(4);
        cmp("R8", "irq_lines cleared", int'(irq_lines), 0);
        write_ctrl(8'hF0);
        strobe(3);
        cmp("R8", "irq_lines level 7", int'(irq_lines), 8'h80);
        strobe(4);

        // R9: forbidden level codes
        phase = "R9";
        write_ctrl(8'h80);
        strobe(2);
        cmp("R9", "irq_lines level 0", int'(irq_lines), 0);
        write_ctrl(8'h90);
        cmp("R9", "irq_lines level 1", int'(irq_lines), 0);
        write_ctrl(8'hA0);
        cmp("R9", "pending moves to level 2", int'(irq_lines), 8'h04);
        strobe(4);

        // R10: clear and event in the same cycle
        phase = "R10";
        write_ctrl(8'hC0);
        strobe(2);
        @(negedge clk); #1 stat_clr = 1'b1; eoc_evt = 1'b1;
        @(negedge clk); #1 stat_clr = 1'b0; eoc_evt = 1'b0;
        cmp("R10", "irq_lines kept", int'(irq_lines), 8'h10);
        strobe(4);
        cmp("R10", "irq_lines cleared", int'(irq_lines), 0);

        // R12: disabled interrupts do not record events
        phase = "R12";
        write_ctrl(8'h40);
        strobe(2); strobe(3);
        write_ctrl(8'hC0);
        idle(2);
        cmp("R12", "irq_lines after enable", int'(irq_lines), 0);

        // R11: DMA gating
        phase = "R11";
        write_ctrl(8'h00);
        @(negedge clk); #1 dma_rdy = 1'b1;
        @(negedge clk);
        cmp("R11", "dma_req disabled", int'(dma_req), 0);
        write_ctrl(8'h04);
        cmp("R11", "dma_req enabled", int'(dma_req), 1);
        #1 dma_rdy = 1'b0;
        @(negedge clk);
        cmp("R11", "dma_req no data", int'(dma_req), 0);
        idle(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule